// File: doc/BRIEF.md
# SMBus Host Register File

This block is the byte-wide register file that sits between software and the transaction engine of an SMBus host. Software programs the slave address, command byte, data bytes, the packet-error-code byte and a small auxiliary control field, then writes the control register with a command code and the start bit. The block turns that write into a one-cycle start pulse for the engine. It raises a busy flag and collects the engine's event pulses into sticky status flags, which software clears by writing ones.

A kill bit in the control register ends a running transaction. The busy flag drops and a failed flag is raised in place of the normal completion flag. A status bit works as a software semaphore: reading it while clear returns zero and sets it. An interrupt output is raised from the completion and error flags when software enables it. Reads are registered and return data the cycle after the read strobe.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `eng_start`, `eng_kill`, `eng_cmd` are 0.
- R2: Status bits 7 (byte done), 6 (in use), 5 (alert), 4 (failed), 3 (bus error), 2 (device error) and 1 (done) at offset 0 clear only when a one is written to that bit position. Writing zero leaves them unchanged. An event that sets a flag in the same cycle as a clearing write wins.
- R3: Status bit 0 (busy) is read-only: writes to the status register never change it.
- R4: A control write (offset 2) with bit 6 (start) set, bit 1 (kill) clear and busy clear produces `eng_start` high for exactly one cycle and sets busy. Bits 5:2 are the command code, driven on `eng_cmd`. Bit 7 drives `eng_pec_en`, bit 0 is the interrupt enable, and bit 6 always reads back 0.
- R5: A control write with bit 6 set while busy is set is ignored entirely: the stored control value is unchanged and no start pulse is produced.
- R6: `ev_done` sets bit 1, `ev_dev_err` sets bit 2 and `ev_bus_err` sets bit 3, and each of these clears busy. `ev_byte_done` sets bit 7 and `ev_alert` sets bit 5 without touching busy.
- R7: Control bit 1 is driven on `eng_kill`. While it is held and busy is set, the next cycle clears busy and sets failed (bit 4) without setting done.
- R8: A status read that finds bit 6 clear returns it as 0 and leaves it set for later reads.
- R9: `irq` equals control bit 0 AND the OR of status bits 1 to 4, registered one cycle after them. Byte done and alert do not raise it.
- R10: Offsets 3 (command byte), 4 (slave address, 7-bit address in bits 7:1 and read flag in bit 0), 5 (data0), 6 (data1) and 8 (PEC byte) read back what was written. Offset 13 keeps bits 1:0, and bit 0 drives `eng_crc_en`. All other offsets read 0.
- R11: `ev_data_we` loads `ev_data_lo` into data0 and `ev_data_hi` into data1 (word low byte in data0, high byte in data1), taking priority over a bus write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| eng_start | output | 1 | One-cycle start request to the engine |
| eng_kill | output | 1 | Abort request to the engine |
| eng_cmd | output | 4 | Command code |
| eng_pec_en | output | 1 | PEC append/check enable |
| eng_crc_en | output | 1 | Hardware CRC enable from auxiliary control |
| eng_slave | output | 8 | Slave address byte |
| eng_cmdbyte | output | 8 | Command byte |
| eng_data0 | output | 8 | Data0 byte |
| eng_data1 | output | 8 | Data1 byte |
| eng_pec_byte | output | 8 | PEC byte |
| ev_done | input | 1 | Engine: transaction completed |
| ev_dev_err | input | 1 | Engine: no acknowledge from device |
| ev_bus_err | input | 1 | Engine: arbitration lost |
| ev_byte_done | input | 1 | Engine: one byte transferred |
| ev_alert | input | 1 | Engine: alert seen |
| ev_data_we | input | 1 | Engine: load received data bytes |
| ev_data_lo | input | 8 | Received low byte |
| ev_data_hi | input | 8 | Received high byte |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are those where two agents touch the same state in one cycle. One is a clearing write that lands in the same cycle as the engine event that sets the same flag. Another is a kill that arrives while a transaction is still busy, and a third is a second start issued before the first one ends. The stimulus reaches these cases with directed sequences that drive a status write and an event pulse on the same clock. It also issues a start, then a second start and a kill before any completion event. Seeded random operations mixing starts, kills, events, clears and reads then wander through the remaining orderings against a bench model.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;
  localparam int DW = 8;

  // register offsets (software-visible map)
  localparam int OFS_STS  = 0;
  localparam int OFS_CTL  = 2;
  localparam int OFS_CMD  = 3;
  localparam int OFS_ADR  = 4;
  localparam int OFS_D0   = 5;
  localparam int OFS_D1   = 6;
  localparam int OFS_PEC  = 8;
  localparam int OFS_AUXC = 13;

  // status bit positions
  localparam int B_BUSY  = 0;
  localparam int B_DONE  = 1;
  localparam int B_DEV   = 2;
  localparam int B_BUS   = 3;
  localparam int B_FAIL  = 4;
  localparam int B_ALERT = 5;
  localparam int B_INUSE = 6;
  localparam int B_BDONE = 7;

  // control bit positions
  localparam int C_IE    = 0;
  localparam int C_KILL  = 1;
  localparam int C_CMDLO = 2;
  localparam int CMD_W   = 4;
  localparam int C_START = 6;
  localparam int C_PEC   = 7;

  localparam int AUX_W   = 2;

  localparam logic [DW-1:0] W1C_MASK = 8'hFE;
  localparam logic [DW-1:0] IRQ_MASK = 8'h1E;

  // plain byte registers, in generate order
  localparam int NRW = 5;

  typedef struct packed {
    logic done;
    logic dev_err;
    logic bus_err;
    logic byte_done;
    logic alert;
  } smb_evt_t;

  function automatic int rw_ofs(input int i);
    case (i)
      0:       return OFS_CMD;
      1:       return OFS_ADR;
      2:       return OFS_D0;
      3:       return OFS_D1;
      default: return OFS_PEC;
    endcase
  endfunction
endpackage

// File: rtl/smb_status_flags.sv
module smb_status_flags
  import smb_regs_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  input  logic          rd_probe,
  input  logic          start_ok,
  input  logic          kill_held,
  input  smb_evt_t      evt,
  output logic [DW-1:0] sts
);
  logic [DW-1:0] nxt;
  logic          kill_abort;
  logic          end_evt;

  assign kill_abort = kill_held & sts[B_BUSY];
  assign end_evt    = evt.done | evt.dev_err | evt.bus_err | kill_abort;

  always_comb begin
    nxt = sts;
    if (wr_en)         nxt = nxt & ~(wdata & W1C_MASK);
    if (rd_probe)      nxt[B_INUSE] = 1'b1;
    if (evt.done)      nxt[B_DONE]  = 1'b1;
    if (evt.dev_err)   nxt[B_DEV]   = 1'b1;
    if (evt.bus_err)   nxt[B_BUS]   = 1'b1;
    if (evt.byte_done) nxt[B_BDONE] = 1'b1;
    if (evt.alert)     nxt[B_ALERT] = 1'b1;
    if (kill_abort)    nxt[B_FAIL]  = 1'b1;
    if (start_ok)      nxt[B_BUSY]  = 1'b1;
    else if (end_evt)  nxt[B_BUSY]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) sts <= '0;
    else     sts <= nxt;
  end

  // R7: a held kill during busy aborts with failed set
  a_r7_kill_abort: assert property (@(posedge clk) disable iff (rst)
    (kill_held && sts[B_BUSY]) |=> (!sts[B_BUSY] && sts[B_FAIL]));

  // R2: done flag only falls after a one written to its position
  a_r2_done_w1c: assert property (@(posedge clk) disable iff (rst)
    $fell(sts[B_DONE]) |-> $past(wr_en && wdata[B_DONE]));

  // R2: failed flag only falls after a one written to its position
  a_r2_fail_w1c: assert property (@(posedge clk) disable iff (rst)
    $fell(sts[B_FAIL]) |-> $past(wr_en && wdata[B_FAIL]));

  // R3: busy only rises on an accepted start
  a_r3_busy_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sts[B_BUSY]) |-> $past(start_ok));
endmodule

// File: rtl/smb_ctl_reg.sv
module smb_ctl_reg
  import smb_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             busy,
  output logic [DW-1:0]    ctl,
  output logic             start_ok,
  output logic             eng_start,
  output logic             kill,
  output logic [CMD_W-1:0] cmd,
  output logic             pec_en,
  output logic             irq_en
);
  logic accept;

  assign accept   = wr_en & ~(wdata[C_START] & busy);
  assign start_ok = wr_en & wdata[C_START] & ~wdata[C_KILL] & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      eng_start <= 1'b0;
    end else begin
      if (accept) begin
        ctl          <= wdata;
        ctl[C_START] <= 1'b0;
      end
      eng_start <= start_ok;
    end
  end

  assign kill   = ctl[C_KILL];
  assign cmd    = ctl[C_CMDLO +: CMD_W];
  assign pec_en = ctl[C_PEC];
  assign irq_en = ctl[C_IE];

  // R5: a start written during busy changes nothing
  a_r5_start_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[C_START] && busy) |=> ($stable(ctl) && !eng_start));

  // R4: start pulse lasts one cycle
  a_r4_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);
endmodule

// File: rtl/smb_data_regs.sv
module smb_data_regs
  import smb_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     ev_we,
  input  logic [DW-1:0]            ev_lo,
  input  logic [DW-1:0]            ev_hi,
  output logic [NRW-1:0][DW-1:0]   rw_q,
  output logic [AUX_W-1:0]         aux_q
);
  for (genvar g = 0; g < NRW; g++) begin : g_byte
    localparam int  OFS  = rw_ofs(g);
    localparam bit  EVLD = (OFS == OFS_D0) || (OFS == OFS_D1);
    logic [DW-1:0] ev_val;
    if (EVLD) begin : g_ev
      assign ev_val = (OFS == OFS_D0) ? ev_lo : ev_hi;
    end else begin : g_noev
      assign ev_val = '0;
    end
    always_ff @(posedge clk) begin
      if (rst)                                         rw_q[g] <= '0;
      else if (EVLD && ev_we)                          rw_q[g] <= ev_val;
      else if (wr_en && addr == ADDR_W'(OFS))          rw_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  aux_q <= '0;
    else if (wr_en && addr == ADDR_W'(OFS_AUXC)) aux_q <= wdata[AUX_W-1:0];
  end

  // R11: engine load lands in data0 / data1
  a_r11_word_load: assert property (@(posedge clk) disable iff (rst)
    ev_we |=> (rw_q[2] == $past(ev_lo) && rw_q[3] == $past(ev_hi)));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_regs_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              eng_start,
  output logic              eng_kill,
  output logic [3:0]        eng_cmd,
  output logic              eng_pec_en,
  output logic              eng_crc_en,
  output logic [7:0]        eng_slave,
  output logic [7:0]        eng_cmdbyte,
  output logic [7:0]        eng_data0,
  output logic [7:0]        eng_data1,
  output logic [7:0]        eng_pec_byte,
  input  logic              ev_done,
  input  logic              ev_dev_err,
  input  logic              ev_bus_err,
  input  logic              ev_byte_done,
  input  logic              ev_alert,
  input  logic              ev_data_we,
  input  logic [7:0]        ev_data_lo,
  input  logic [7:0]        ev_data_hi,
  output logic              irq
);
  logic [DW-1:0]          sts, ctl;
  logic [NRW-1:0][DW-1:0] rw_q;
  logic [AUX_W-1:0]       aux_q;
  logic                   wr_sts, wr_ctl, rd_sts;
  logic                   start_ok, kill, irq_en;
  smb_evt_t               evt;
  logic [DW-1:0]          rd_mux;

  assign wr_sts = bus_wr && bus_addr == ADDR_W'(OFS_STS);
  assign wr_ctl = bus_wr && bus_addr == ADDR_W'(OFS_CTL);
  assign rd_sts = bus_rd && bus_addr == ADDR_W'(OFS_STS);

  assign evt = '{done: ev_done, dev_err: ev_dev_err, bus_err: ev_bus_err,
                 byte_done: ev_byte_done, alert: ev_alert};

  smb_status_flags u_sts (
    .clk(clk), .rst(rst), .wr_en(wr_sts), .wdata(bus_wdata),
    .rd_probe(rd_sts), .start_ok(start_ok), .kill_held(kill),
    .evt(evt), .sts(sts)
  );

  smb_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr_en(wr_ctl), .wdata(bus_wdata),
    .busy(sts[B_BUSY]), .ctl(ctl), .start_ok(start_ok),
    .eng_start(eng_start), .kill(kill), .cmd(eng_cmd),
    .pec_en(eng_pec_en), .irq_en(irq_en)
  );

  smb_data_regs #(.ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .ev_we(ev_data_we), .ev_lo(ev_data_lo), .ev_hi(ev_data_hi),
    .rw_q(rw_q), .aux_q(aux_q)
  );

  assign eng_kill     = kill;
  assign eng_crc_en   = aux_q[0];
  assign eng_cmdbyte  = rw_q[0];
  assign eng_slave    = rw_q[1];
  assign eng_data0    = rw_q[2];
  assign eng_data1    = rw_q[3];
  assign eng_pec_byte = rw_q[4];

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_STS))  rd_mux = sts;
    if (bus_addr == ADDR_W'(OFS_CTL))  rd_mux = ctl;
    if (bus_addr == ADDR_W'(OFS_AUXC)) rd_mux = {{(DW-AUX_W){1'b0}}, aux_q};
    for (int i = 0; i < NRW; i++)
      if (bus_addr == ADDR_W'(rw_ofs(i))) rd_mux = rw_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= irq_en & |(sts & IRQ_MASK);
    end
  end

  // R4: start pulse always sees busy set
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> sts[B_BUSY]);

  // R9: interrupt stays low when enable was off
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    $past(!irq_en) |-> !irq);
endmodule

// File: tb/smb_host_regs_bench.sv
`timescale 1ns/1ps
module smb_host_regs_bench;
  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic eng_start, eng_kill, eng_pec_en, eng_crc_en;
  logic [3:0] eng_cmd;
  logic [7:0] eng_slave, eng_cmdbyte, eng_data0, eng_data1, eng_pec_byte;
  logic ev_done = 0, ev_dev_err = 0, ev_bus_err = 0, ev_byte_done = 0, ev_alert = 0;
  logic ev_data_we = 0;
  logic [7:0] ev_data_lo = 0, ev_data_hi = 0;
  logic irq;

  int checks = 0, errors = 0;
  logic [7:0] m_sts = 0, m_ctl = 0;
  logic [7:0] m_reg [16];

  always #2 clk = ~clk;

  smb_host_regs u_smb_host_regs (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return m_ctl[0] && |(m_sts & 8'h1E);
  endfunction

  function automatic logic [7:0] exp_read(input int a);
    if (a == 0) return m_sts;
    if (a == 2) return m_ctl;
    return m_reg[a];
  endfunction

  task automatic bus_write(input int a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input int a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = 4'(a);
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  // model-tracked operations
  task automatic op_write(input int a, input logic [7:0] d);
    bus_write(a, d);
    if (a == 0) m_sts = m_sts & ~(d & 8'hFE);
    else if (a == 2) begin
      if (!(d[6] && m_sts[0])) begin
        if (d[6] && !d[1]) m_sts[0] = 1;
        m_ctl = d & 8'hBF;
        if (m_ctl[1] && m_sts[0]) begin m_sts[0] = 0; m_sts[4] = 1; end
      end
    end
    else if (a == 13) m_reg[a] = d & 8'h03;
    else if (a inside {3, 4, 5, 6, 8}) m_reg[a] = d;
  endtask

  task automatic op_read(input int a, input string req);
    logic [7:0] got, exp;
    exp = exp_read(a);
    bus_read(a, got);
    chk(got == exp, req, got, exp);
    if (a == 0) m_sts[6] = 1;
  endtask

  // which = {alert, byte_done, bus, dev, done}
  task automatic op_event(input logic [4:0] w, input logic we, input logic [7:0] lo, hi);
    @(negedge clk);
    {ev_alert, ev_byte_done, ev_bus_err, ev_dev_err, ev_done} = w;
    ev_data_we = we; ev_data_lo = lo; ev_data_hi = hi;
    @(negedge clk);
    {ev_alert, ev_byte_done, ev_bus_err, ev_dev_err, ev_done} = '0;
    ev_data_we = 0;
    if (w[0]) begin m_sts[1] = 1; m_sts[0] = 0; end
    if (w[1]) begin m_sts[2] = 1; m_sts[0] = 0; end
    if (w[2]) begin m_sts[3] = 1; m_sts[0] = 0; end
    if (w[3]) m_sts[7] = 1;
    if (w[4]) m_sts[5] = 1;
    if (we) begin m_reg[5] = lo; m_reg[6] = hi; end
  endtask

  task automatic settle_and_check();
    repeat (2) @(negedge clk);
    chk(irq == exp_irq(), "R9 irq", irq, exp_irq());
    chk(eng_kill == m_ctl[1], "R7 eng_kill", eng_kill, m_ctl[1]);
    chk(eng_cmd == m_ctl[5:2], "R4 eng_cmd", eng_cmd, m_ctl[5:2]);
    chk(eng_crc_en == m_reg[13][0], "R10 crc enable", eng_crc_en, m_reg[13][0]);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) m_reg[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset state
    chk(irq == 0 && eng_start == 0 && eng_kill == 0 && eng_cmd == 0, "R1 outputs", irq, 0);
    for (int a = 1; a < 16; a++) op_read(a, "R1 reset readback");
    op_read(0, "R1 status reset");
    op_read(0, "R8 in-use set after first read");
    op_write(0, 8'h40);

    // R4: start pulse, word command, interrupt enable
    op_write(2, 8'h4D);
    chk(eng_start == 1, "R4 start pulse", eng_start, 1);
    @(negedge clk);
    chk(eng_start == 0, "R4 start width", eng_start, 0);
    chk(eng_cmd == 4'h3, "R4 cmd field", eng_cmd, 3);
    op_read(2, "R4 start reads 0");

    // R5: second start while busy
    op_write(2, 8'h54);
    chk(eng_start == 0, "R5 no pulse while busy", eng_start, 0);
    op_read(2, "R5 control unchanged");

    // R3: writes to busy ignored
    op_write(0, 8'hFF);
    op_read(0, "R3 busy survives write");

    // R2: set wins over same-cycle clear; R6 done ends busy
    @(negedge clk);
    bus_wr = 1; bus_addr = 0; bus_wdata = 8'h02; ev_done = 1;
    @(negedge clk);
    bus_wr = 0; ev_done = 0;
    m_sts[1] = 1; m_sts[0] = 0;
    op_read(0, "R2 set beats clear, R6 done");
    settle_and_check();
    op_write(0, 8'h02);
    op_read(0, "R2 done cleared by one");

    // R7: kill during busy
    op_write(2, 8'h41);
    op_write(2, 8'h03);
    @(negedge clk);
    op_read(0, "R7 kill aborts with failed");
    chk(eng_kill == 1, "R7 eng_kill driven", eng_kill, 1);
    settle_and_check();

    // R9: enable off masks interrupt
    op_write(2, 8'h00);
    settle_and_check();
    op_write(0, 8'hFF);

    // R6: byte done keeps busy, device error ends it
    op_write(2, 8'h59);
    op_event(5'b01000, 0, 0, 0);
    op_read(0, "R6 byte done keeps busy");
    op_event(5'b00010, 0, 0, 0);
    op_read(0, "R6 device error ends busy");

    // R11: word load, priority over bus write
    @(negedge clk);
    bus_wr = 1; bus_addr = 5; bus_wdata = 8'hEE;
    ev_data_we = 1; ev_data_lo = 8'h34; ev_data_hi = 8'h12;
    @(negedge clk);
    bus_wr = 0; ev_data_we = 0;
    m_reg[5] = 8'h34; m_reg[6] = 8'h12;
    op_read(5, "R11 low byte in data0");
    op_read(6, "R11 high byte in data1");
    chk(eng_data0 == 8'h34 && eng_data1 == 8'h12, "R11 engine data", eng_data0, 8'h34);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 7);
      int dofs [6] = '{3, 4, 5, 6, 8, 13};
      int uofs [8] = '{1, 7, 9, 10, 11, 12, 14, 15};
      case (op)
        0: op_write(dofs[$urandom_range(0, 5)], 8'($urandom));
        1: op_read(dofs[$urandom_range(0, 5)], "R10 data readback");
        2: op_write(2, 8'($urandom));
        3: op_event(5'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
        4: op_write(0, 8'($urandom));
        5: op_read(0, "R2 status model");
        6: op_read(2, "R4 control readback");
        default: op_read(uofs[$urandom_range(0, 7)], "R10 unmapped reads 0");
      endcase
      settle_and_check();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule